// File: doc/BRIEF.md
# Serial Flash Slave Command Controller

This block stands in for the command engine of a serial flash device on an SPI bus. It serves an on-chip byte array of 1 KB, split into 256-byte pages and 256-byte sectors. A host drives SPI mode 0 frames under an active-low select. The block samples the bus pins with its own system clock and decodes a one-byte opcode at the start of each frame. It can then read the array, program a page, erase a sector or the whole array, report or update its status, and enter or leave a low-power state in which it ignores the bus.

Program and erase work as in real flash. Programming can only pull bits low, and erasing returns bytes to FFh. Each change needs a write-enable step first. It runs as a timed internal cycle that the host polls through the busy bit. The cycle finishes on its own after chip select has gone high. A three-bit protection field guards the upper sectors against program and erase.

Top module: `sflash_cmd_ctrl`

## Requirements
- R1: Frames are SPI mode 0, with bits sent MSB first and sampled on the rising SCLK edge. MISO changes on falling edges and is held at 0 while chip select is high.
- R2: Opcode 05h returns the status byte repeatedly for as long as the frame lasts. The status byte holds busy in bit 0, the write-enable latch in bit 1 and the protection field in bits 4:2, with bits 7:5 at 0.
- R3: Opcode 03h is followed by three address bytes, sent MSB first, of which the low 10 bits are used. The block then returns bytes from consecutive addresses, wrapping from 3FFh to 000h. After reset every byte reads FFh.
- R4: Opcode 02h is followed by three address bytes and at least one data byte. Each stored byte becomes its old value ANDed with the data. Addresses past the end of the page wrap to the start of the same page, and the page changes when the internal cycle ends.
- R5: Program (02h), sector erase (D8h), bulk erase (C7h) and status write (01h) take effect only if the write-enable latch was set beforehand by 06h. Without it they leave the array and the status unchanged.
- R6: An accepted program, erase or status write sets busy for a fixed number of clock cycles (PROG_CYCLES, SE_CYCLES, BE_CYCLES, WS_CYCLES). When busy drops, the write-enable latch clears.
- R7: Sector erase (D8h plus three address bytes) sets the addressed 256-byte sector to FFh. Bulk erase (C7h) sets the whole array to FFh. Bytes outside the erased range keep their values.
- R8: A protection field value n protects the top min(n,4) sectors. A program or sector erase that targets a protected sector, or a bulk erase while n is not 0, is rejected. A rejected command leaves the memory and the write-enable latch unchanged.
- R9: While busy, every opcode except 05h is ignored, and MISO stays 0 for the ignored ones.
- R10: After B9h the block ignores every opcode except ABh, which returns it to normal operation. While it is asleep, MISO stays 0 and a set write-enable latch is kept.
- R11: A command takes effect only if chip select rises right after a whole byte and the frame has the exact length the command needs. The needed lengths are 1 byte for 06h, B9h, ABh and C7h, 2 bytes for 01h, 4 bytes for D8h, and at least 5 bytes for 02h.
- R12: Status write (01h plus one byte) loads bits 4:2 of the data byte into the protection field. The new value is visible at once, and the write then runs its timed busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing each command |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
A wrong internal state almost always shows up at the ports in the next frame the host sends. A lost or stuck write-enable latch, a wrong protection field, or a busy flag that never clears shows up in the next status read. A program that sets bits or misplaces its wrap shows up in the next array read after busy drops. A misdecoded opcode or an execution on a partial byte appears one frame later as a status or data byte that differs from the expected value. Sleep and busy are checked by sending commands that must be ignored and then reading back the state they would have changed.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam logic [7:0] OPC_NONE   = 8'h00;
    localparam logic [7:0] OPC_WSTAT  = 8'h01;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_RSTAT  = 8'h05;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_BERASE = 8'hC7;
    localparam logic [7:0] OPC_SERASE = 8'hD8;
    localparam logic [7:0] OPC_SLEEP  = 8'hB9;
    localparam logic [7:0] OPC_WAKE   = 8'hAB;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PROG,
        OP_SERASE,
        OP_BERASE,
        OP_WSTAT
    } op_e;

    function automatic logic opc_known(input logic [7:0] b);
        return (b == OPC_WSTAT) || (b == OPC_PROG) || (b == OPC_READ) ||
               (b == OPC_RSTAT) || (b == OPC_WREN) || (b == OPC_BERASE) ||
               (b == OPC_SERASE) || (b == OPC_SLEEP) || (b == OPC_WAKE);
    endfunction
endpackage

// File: rtl/sfc_link.sv
module sfc_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       cs_n_i,
    input  logic       mosi_i,
    input  logic [7:0] tx_next_i,
    output logic       byte_done_o,
    output logic [7:0] rx_byte_o,
    output logic       sel_start_o,
    output logic       sel_end_o,
    output logic       sel_aligned_o,
    output logic       miso_o
);
    typedef struct packed {
        logic [1:0] sclk_sy;
        logic [1:0] cs_sy;
        logic [1:0] mosi_sy;
        logic       sclk_prev;
        logic       cs_prev;
        logic [2:0] bit_cnt;
        logic [7:0] rx_sh;
        logic [7:0] tx_sh;
        logic       done;
        logic [7:0] rx;
        logic       start;
        logic       fin;
        logic       aligned;
    } link_t;

    link_t q, d;
    logic  sclk_now, cs_now, mosi_now, rise, fall;

    always_comb begin
        sclk_now = q.sclk_sy[1];
        cs_now   = q.cs_sy[1];
        mosi_now = q.mosi_sy[1];
        rise     = sclk_now && !q.sclk_prev;
        fall     = !sclk_now && q.sclk_prev;

        d           = q;
        d.sclk_sy   = {q.sclk_sy[0], sclk_i};
        d.cs_sy     = {q.cs_sy[0], cs_n_i};
        d.mosi_sy   = {q.mosi_sy[0], mosi_i};
        d.sclk_prev = sclk_now;
        d.cs_prev   = cs_now;
        d.done      = 1'b0;
        d.start     = 1'b0;
        d.fin       = 1'b0;

        if (!cs_now && q.cs_prev) begin
            d.start   = 1'b1;
            d.bit_cnt = 3'd0;
            d.tx_sh   = 8'h00;
        end else if (cs_now && !q.cs_prev) begin
            d.fin     = 1'b1;
            d.aligned = (q.bit_cnt == 3'd0);
            d.tx_sh   = 8'h00;
        end else if (!cs_now) begin
            if (rise) begin
                d.rx_sh   = {q.rx_sh[6:0], mosi_now};
                d.bit_cnt = q.bit_cnt + 3'd1;
                if (q.bit_cnt == 3'd7) begin
                    d.done = 1'b1;
                    d.rx   = {q.rx_sh[6:0], mosi_now};
                end
            end else if (fall) begin
                if (q.bit_cnt == 3'd0) d.tx_sh = tx_next_i;
                else                   d.tx_sh = {q.tx_sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.cs_sy   <= 2'b11;
            q.cs_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_done_o   = q.done;
    assign rx_byte_o     = q.rx;
    assign sel_start_o   = q.start;
    assign sel_end_o     = q.fin;
    assign sel_aligned_o = q.aligned;
    assign miso_o        = q.tx_sh[7];

    // R1: the output stays low whenever the bus was deselected
    a_r1_miso_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_prev |-> !miso_o);

    // R1: a byte is reported only after the eighth rising edge
    a_r1_byte_on_eighth: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.bit_cnt == 3'd0));
endmodule

// File: rtl/sfc_store.sv
module sfc_store #(
    parameter int ARRAY_BYTES  = 1024,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 256,
    localparam int AW = $clog2(ARRAY_BYTES),
    localparam int OW = $clog2(PAGE_BYTES),
    localparam int PW = AW - OW,
    localparam int SW = AW - $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    input  logic          buf_clear_i,
    input  logic          buf_we_i,
    input  logic [OW-1:0] buf_off_i,
    input  logic [7:0]    buf_data_i,
    input  logic          commit_en_i,
    input  logic [PW-1:0] commit_page_i,
    input  logic          erase_en_i,
    input  logic          erase_all_i,
    input  logic [SW-1:0] erase_sector_i
);
    logic [7:0] mem_q [ARRAY_BYTES];
    logic [7:0] mem_d [ARRAY_BYTES];
    logic [7:0] buf_q [PAGE_BYTES];
    logic [7:0] buf_d [PAGE_BYTES];

    always_comb begin
        mem_d = mem_q;
        buf_d = buf_q;
        if (buf_clear_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) buf_d[i] = 8'hFF;
        end else if (buf_we_i) begin
            buf_d[buf_off_i] = buf_data_i;
        end
        for (int i = 0; i < ARRAY_BYTES; i++) begin
            if (commit_en_i && ((i / PAGE_BYTES) == int'(commit_page_i)))
                mem_d[i] = mem_q[i] & buf_q[i % PAGE_BYTES];
            if (erase_en_i && (erase_all_i || ((i / SECTOR_BYTES) == int'(erase_sector_i))))
                mem_d[i] = 8'hFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ARRAY_BYTES; i++) mem_q[i] <= 8'hFF;
            for (int i = 0; i < PAGE_BYTES; i++)  buf_q[i] <= 8'hFF;
        end else begin
            mem_q <= mem_d;
            buf_q <= buf_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R7: program, erase and buffer fill never coincide
    a_r7_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_en_i, erase_en_i, buf_we_i}));

    // R7: a bulk erase leaves both ends of the array erased
    a_r7_bulk_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en_i && erase_all_i) |=> ((mem_q[0] == 8'hFF) && (mem_q[ARRAY_BYTES-1] == 8'hFF)));

    // R4: a program commit never raises a bit in the first byte of its page
    a_r4_and_only: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en_i |=> ((mem_q[int'($past(commit_page_i)) * PAGE_BYTES] &
                          ~$past(mem_q[int'(commit_page_i) * PAGE_BYTES])) == 8'h00));
endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
    import sfc_pkg::*;
#(
    parameter int ARRAY_BYTES  = 1024,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 256,
    parameter int PROG_CYCLES  = 600,
    parameter int SE_CYCLES    = 2000,
    parameter int BE_CYCLES    = 3000,
    parameter int WS_CYCLES    = 500,
    parameter logic [2:0] BP_INIT = 3'd0,
    localparam int AW = $clog2(ARRAY_BYTES),
    localparam int OW = $clog2(PAGE_BYTES),
    localparam int PW = AW - OW,
    localparam int SW = AW - $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done_i,
    input  logic [7:0]    rx_byte_i,
    input  logic          sel_start_i,
    input  logic          sel_end_i,
    input  logic          sel_aligned_i,
    input  logic [7:0]    rd_data_i,
    output logic [7:0]    tx_next_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          buf_clear_o,
    output logic          buf_we_o,
    output logic [OW-1:0] buf_off_o,
    output logic [7:0]    buf_data_o,
    output logic          commit_en_o,
    output logic [PW-1:0] commit_page_o,
    output logic          erase_en_o,
    output logic          erase_all_o,
    output logic [SW-1:0] erase_sector_o
);
    localparam int NUM_SECTORS = ARRAY_BYTES / SECTOR_BYTES;
    localparam int MAX_A = (PROG_CYCLES > SE_CYCLES) ? PROG_CYCLES : SE_CYCLES;
    localparam int MAX_B = (BE_CYCLES > WS_CYCLES) ? BE_CYCLES : WS_CYCLES;
    localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAXC + 1);
    localparam logic [TW-1:0] T_PROG = TW'(PROG_CYCLES - 1);
    localparam logic [TW-1:0] T_SE   = TW'(SE_CYCLES - 1);
    localparam logic [TW-1:0] T_BE   = TW'(BE_CYCLES - 1);
    localparam logic [TW-1:0] T_WS   = TW'(WS_CYCLES - 1);

    typedef struct packed {
        logic [7:0]    cmd;
        logic [2:0]    cnt;
        logic [AW-1:0] addr;
        logic [2:0]    bp_new;
        logic          wel;
        logic          dp;
        logic          busy;
        logic [2:0]    bp;
        op_e           op;
        logic [TW-1:0] timer;
    } ctl_t;

    ctl_t q, d;
    logic [7:0]    status;
    logic [SW-1:0] addr_sector;

    function automatic logic sector_locked(input logic [2:0] bp, input logic [SW-1:0] sec);
        int n;
        n = (int'(bp) > NUM_SECTORS) ? NUM_SECTORS : int'(bp);
        return (int'(sec) >= (NUM_SECTORS - n));
    endfunction

    assign status      = {3'b000, q.bp, q.wel, q.busy};
    assign addr_sector = q.addr[AW-1 -: SW];

    always_comb begin
        d              = q;
        buf_clear_o    = 1'b0;
        buf_we_o       = 1'b0;
        buf_off_o      = q.addr[OW-1:0];
        buf_data_o     = rx_byte_i;
        commit_en_o    = 1'b0;
        commit_page_o  = q.addr[AW-1 -: PW];
        erase_en_o     = 1'b0;
        erase_all_o    = 1'b0;
        erase_sector_o = addr_sector;

        // byte-level decode
        if (byte_done_i) begin
            if (q.cnt == 3'd0) begin
                logic ok;
                if (q.dp)        ok = (rx_byte_i == OPC_WAKE);
                else if (q.busy) ok = (rx_byte_i == OPC_RSTAT);
                else             ok = opc_known(rx_byte_i);
                d.cmd = ok ? rx_byte_i : OPC_NONE;
                if (ok && (rx_byte_i == OPC_PROG)) buf_clear_o = 1'b1;
            end else begin
                if ((q.cnt <= 3'd3) &&
                    ((q.cmd == OPC_PROG) || (q.cmd == OPC_SERASE) || (q.cmd == OPC_READ)))
                    d.addr = {q.addr[AW-9:0], rx_byte_i};
                if ((q.cnt == 3'd1) && (q.cmd == OPC_WSTAT))
                    d.bp_new = rx_byte_i[4:2];
                if ((q.cnt >= 3'd4) && (q.cmd == OPC_PROG)) begin
                    buf_we_o          = 1'b1;
                    d.addr[OW-1:0]    = q.addr[OW-1:0] + OW'(1);
                end
                if ((q.cnt >= 3'd4) && (q.cmd == OPC_READ))
                    d.addr = q.addr + AW'(1);
            end
            if (q.cnt != 3'd7) d.cnt = q.cnt + 3'd1;
        end

        // frame boundaries and execution
        if (sel_start_i) begin
            d.cmd = OPC_NONE;
            d.cnt = 3'd0;
        end
        if (sel_end_i) begin
            if (sel_aligned_i) begin
                case (q.cmd)
                    OPC_WREN:  if (q.cnt == 3'd1) d.wel = 1'b1;
                    OPC_SLEEP: if (q.cnt == 3'd1) d.dp = 1'b1;
                    OPC_WAKE:  if (q.cnt == 3'd1) d.dp = 1'b0;
                    OPC_PROG: begin
                        if ((q.cnt >= 3'd5) && q.wel && !sector_locked(q.bp, addr_sector)) begin
                            d.busy = 1'b1; d.op = OP_PROG; d.timer = T_PROG;
                        end
                    end
                    OPC_SERASE: begin
                        if ((q.cnt == 3'd4) && q.wel && !sector_locked(q.bp, addr_sector)) begin
                            d.busy = 1'b1; d.op = OP_SERASE; d.timer = T_SE;
                        end
                    end
                    OPC_BERASE: begin
                        if ((q.cnt == 3'd1) && q.wel && (q.bp == 3'd0)) begin
                            d.busy = 1'b1; d.op = OP_BERASE; d.timer = T_BE;
                        end
                    end
                    OPC_WSTAT: begin
                        if ((q.cnt == 3'd2) && q.wel) begin
                            d.bp = q.bp_new;
                            d.busy = 1'b1; d.op = OP_WSTAT; d.timer = T_WS;
                        end
                    end
                    default: ;
                endcase
            end
            d.cmd = OPC_NONE;
            d.cnt = 3'd0;
        end

        // timed internal cycle
        if (q.busy) begin
            if (q.timer == '0) begin
                d.busy = 1'b0;
                d.wel  = 1'b0;
                d.op   = OP_IDLE;
                case (q.op)
                    OP_PROG:   commit_en_o = 1'b1;
                    OP_SERASE: erase_en_o  = 1'b1;
                    OP_BERASE: begin erase_en_o = 1'b1; erase_all_o = 1'b1; end
                    default: ;
                endcase
            end else begin
                d.timer = q.timer - TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.op <= OP_IDLE;
            q.bp <= BP_INIT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (q.cmd == OPC_RSTAT)                        tx_next_o = status;
        else if ((q.cmd == OPC_READ) && (q.cnt >= 3'd4)) tx_next_o = rd_data_i;
        else                                           tx_next_o = 8'h00;
    end
    assign rd_addr_o = q.addr;

    // R5: an internal cycle starts only with the latch already set
    a_r5_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(q.wel));

    // R6: the latch is clear once the cycle ends
    a_r6_wel_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.wel);

    // R9 and R10: the latch cannot be set while busy or asleep
    a_r10_wel_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wel) |-> (!$past(q.dp) && !$past(q.busy)));

    // R8: a sector erase never lands on a protected sector
    a_r8_locked_no_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en_o && !erase_all_o) |-> !sector_locked(q.bp, erase_sector_o));
endmodule

// File: rtl/sflash_cmd_ctrl.sv
module sflash_cmd_ctrl #(
    parameter int ARRAY_BYTES  = 1024,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 256,
    parameter int PROG_CYCLES  = 600,
    parameter int SE_CYCLES    = 2000,
    parameter int BE_CYCLES    = 3000,
    parameter int WS_CYCLES    = 500,
    parameter logic [2:0] BP_INIT = 3'd0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int AW = $clog2(ARRAY_BYTES);
    localparam int OW = $clog2(PAGE_BYTES);
    localparam int PW = AW - OW;
    localparam int SW = AW - $clog2(SECTOR_BYTES);

    logic          byte_done, sel_start, sel_end, sel_aligned;
    logic [7:0]    rx_byte, tx_next, rd_data, buf_data;
    logic [AW-1:0] rd_addr;
    logic          buf_clear, buf_we, commit_en, erase_en, erase_all;
    logic [OW-1:0] buf_off;
    logic [PW-1:0] commit_page;
    logic [SW-1:0] erase_sector;

    sfc_link u_link (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .tx_next_i(tx_next),
        .byte_done_o(byte_done), .rx_byte_o(rx_byte),
        .sel_start_o(sel_start), .sel_end_o(sel_end), .sel_aligned_o(sel_aligned),
        .miso_o(spi_miso)
    );

    sfc_ctrl #(
        .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
        .PROG_CYCLES(PROG_CYCLES), .SE_CYCLES(SE_CYCLES), .BE_CYCLES(BE_CYCLES),
        .WS_CYCLES(WS_CYCLES), .BP_INIT(BP_INIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .byte_done_i(byte_done), .rx_byte_i(rx_byte),
        .sel_start_i(sel_start), .sel_end_i(sel_end), .sel_aligned_i(sel_aligned),
        .rd_data_i(rd_data), .tx_next_o(tx_next), .rd_addr_o(rd_addr),
        .buf_clear_o(buf_clear), .buf_we_o(buf_we), .buf_off_o(buf_off), .buf_data_o(buf_data),
        .commit_en_o(commit_en), .commit_page_o(commit_page),
        .erase_en_o(erase_en), .erase_all_o(erase_all), .erase_sector_o(erase_sector)
    );

    sfc_store #(
        .ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .buf_clear_i(buf_clear), .buf_we_i(buf_we), .buf_off_i(buf_off), .buf_data_i(buf_data),
        .commit_en_i(commit_en), .commit_page_i(commit_page),
        .erase_en_i(erase_en), .erase_all_i(erase_all), .erase_sector_i(erase_sector)
    );
endmodule

// File: tb/sflash_cmd_ctrl_bench.sv
module sflash_cmd_ctrl_bench;
    localparam int H = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    int   total = 0, bad = 0;
    bit   done = 1'b0;
    logic [7:0] txb [16];
    logic [7:0] rxb [16];

    // address, data, expected stored value after the program
    localparam logic [25:0] PVEC [6] = '{
        {10'h005, 8'hA5, 8'hA5},
        {10'h005, 8'h3C, 8'h24},
        {10'h1FF, 8'h0F, 8'h0F},
        {10'h300, 8'hF0, 8'hF0},
        {10'h300, 8'hFF, 8'hF0},
        {10'h2AB, 8'h00, 8'h00}
    };

    always #10 clk = ~clk;

    sflash_cmd_ctrl u_sflash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", what, act, exp);
        end
    endtask

    task automatic xfer(input int n, input int extra);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < n + 1; i++) begin
            int nb;
            nb = (i < n) ? 8 : extra;
            if (i < n) rxb[i] = 8'h00;
            for (int b = 7; b > 7 - nb; b--) begin
                mosi = (i < n) ? txb[i][b] : 1'b0;
                repeat (H) @(negedge clk);
                sclk = 1'b1;
                if (i < n) rxb[i][b] = miso;
                repeat (H) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        txb[0] = op;
        xfer(1, 0);
    endtask

    task automatic rd_status(output logic [7:0] s);
        txb[0] = 8'h05; txb[1] = 8'h00;
        xfer(2, 0);
        s = rxb[1];
    endtask

    task automatic rd_byte(input logic [9:0] a, output logic [7:0] v);
        txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = {6'b0, a[9:8]}; txb[3] = a[7:0]; txb[4] = 8'h00;
        xfer(5, 0);
        v = rxb[4];
    endtask

    task automatic prog1(input logic [9:0] a, input logic [7:0] v);
        txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = {6'b0, a[9:8]}; txb[3] = a[7:0]; txb[4] = v;
        xfer(5, 0);
    endtask

    task automatic serase(input logic [9:0] a);
        txb[0] = 8'hD8; txb[1] = 8'h00; txb[2] = {6'b0, a[9:8]}; txb[3] = a[7:0];
        xfer(4, 0);
    endtask

    task automatic wstat(input logic [7:0] v);
        txb[0] = 8'h01; txb[1] = v;
        xfer(2, 0);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 100; k++) begin
            rd_status(s);
            if (!s[0]) break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got 00 expected 01");
        finish_run();
    end

    initial begin
        logic [7:0] s, v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        check("R1 miso low while deselected", {7'b0, miso}, 8'h00);
        rd_status(s); check("R2 status after reset", s, 8'h00);
        rd_byte(10'h000, v); check("R3 erased byte after reset", v, 8'hFF);

        // R11: write enable ended three bits into a second byte
        txb[0] = 8'h06; xfer(1, 3);
        rd_status(s); check("R11 misaligned write enable ignored", s, 8'h00);

        // R2: latch visible, status repeats
        cmd1(8'h06);
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; xfer(3, 0);
        check("R2 status first byte", rxb[1], 8'h02);
        check("R2 status repeated", rxb[2], 8'h02);

        // table of single-byte programs
        for (int i = 0; i < 6; i++) begin
            logic [9:0] a;
            a = PVEC[i][25:16];
            cmd1(8'h06);
            prog1(a, PVEC[i][15:8]);
            rd_status(s); check("R6 busy and latch during program", s, 8'h03);
            wait_idle();
            rd_status(s); check("R6 latch cleared after program", s, 8'h00);
            rd_byte(a, v); check("R4 stored value is old AND new", v, PVEC[i][7:0]);
        end

        // R4: program running past the end of page 0
        cmd1(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'hFE;
        txb[4] = 8'h11; txb[5] = 8'h22; txb[6] = 8'h33; txb[7] = 8'h44;
        xfer(8, 0);
        wait_idle();
        txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'hFE; txb[4] = 8'h00; txb[5] = 8'h00;
        xfer(6, 0);
        check("R4 page byte FE", rxb[4], 8'h11);
        check("R4 page byte FF", rxb[5], 8'h22);
        txb[3] = 8'h00; xfer(6, 0);
        check("R4 wrapped to page start", rxb[4], 8'h33);
        check("R4 wrapped second byte", rxb[5], 8'h44);

        // R3: read across the top of the array
        txb[0] = 8'h03; txb[1] = 8'h00; txb[2] = 8'h03; txb[3] = 8'hFF; txb[4] = 8'h00; txb[5] = 8'h00;
        xfer(6, 0);
        check("R3 last byte", rxb[4], 8'hFF);
        check("R3 read wraps to 000", rxb[5], 8'h33);

        // R5: program without write enable
        prog1(10'h010, 8'h00);
        rd_status(s); check("R5 no cycle without latch", s, 8'h00);
        rd_byte(10'h010, v); check("R5 byte unchanged without latch", v, 8'hFF);

        // R9 and R7: sector erase, commands during busy ignored
        cmd1(8'h06);
        serase(10'h100);
        cmd1(8'h06);
        rd_byte(10'h1FF, v); check("R9 read ignored while busy", v, 8'h00);
        rd_status(s); check("R9 status still served while busy", s, 8'h03);
        wait_idle();
        rd_status(s); check("R9 write enable during busy was ignored", s, 8'h00);
        rd_byte(10'h1FF, v); check("R7 sector erased", v, 8'hFF);
        rd_byte(10'h0FF, v); check("R7 other sector kept", v, 8'h22);

        // R12 and R8: protect the top sector
        cmd1(8'h06);
        wstat(8'h04);
        rd_status(s); check("R12 new field visible during write", s, 8'h07);
        wait_idle();
        rd_status(s); check("R12 field kept, latch cleared", s, 8'h04);
        cmd1(8'h06);
        prog1(10'h300, 8'h00);
        rd_status(s); check("R8 rejected program keeps latch", s, 8'h06);
        rd_byte(10'h300, v); check("R8 protected byte unchanged by program", v, 8'hF0);
        serase(10'h300);
        rd_status(s); check("R8 rejected sector erase", s, 8'h06);
        rd_byte(10'h300, v); check("R8 protected byte unchanged by erase", v, 8'hF0);
        cmd1(8'hC7);
        rd_status(s); check("R8 bulk erase rejected while protected", s, 8'h06);
        rd_byte(10'h2AB, v); check("R8 array kept after rejected bulk erase", v, 8'h00);
        prog1(10'h210, 8'h5A);
        wait_idle();
        rd_byte(10'h210, v); check("R8 unprotected sector programmable", v, 8'h5A);
        rd_status(s); check("R8 latch cleared after allowed program", s, 8'h04);
        cmd1(8'h06);
        wstat(8'h00);
        wait_idle();
        rd_status(s); check("R12 protection removed", s, 8'h00);

        // R7: bulk erase
        cmd1(8'h06);
        cmd1(8'hC7);
        wait_idle();
        rd_byte(10'h2AB, v); check("R7 bulk erase sector 2", v, 8'hFF);
        rd_byte(10'h005, v); check("R7 bulk erase sector 0", v, 8'hFF);

        // R11: sector erase one byte short
        cmd1(8'h06);
        txb[0] = 8'hD8; txb[1] = 8'h00; txb[2] = 8'h00; xfer(3, 0);
        rd_status(s); check("R11 short erase frame not executed", s, 8'h02);

        // R10: sleep and wake
        cmd1(8'hB9);
        rd_status(s); check("R10 status silent while asleep", s, 8'h00);
        prog1(10'h020, 8'h00);
        cmd1(8'hAB);
        rd_status(s); check("R10 latch kept across sleep", s, 8'h02);
        rd_byte(10'h020, v); check("R10 program while asleep ignored", v, 8'hFF);

        finish_run();
    end
endmodule